// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block controls a successive-approximation converter through a small word-addressed register bus. Software sets the enable bit and the block switches on the converter's regulator at once. After a programmable power-up delay it enables the converter. Each conversion has three steps: a sample window of programmable length, a one-cycle start-of-conversion pulse, and a capture of the 10-bit sample into a result register. The capture happens either on the converter's synchronised done handshake or a fixed number of clocks after the start pulse.

Software starts a conversion by writing a start bit, which stays set while the block is busy. A completed conversion raises an interrupt flag. A maskable interrupt line follows that flag, and a write of any value to a dedicated register clears it. In continuous mode the block keeps converting and overwrites the result each time. A programmable number of interval ticks separates the conversions; the tick period is a parameter and is 1.024 ms of system clock by default. The analog parts are not modelled. Configuration bits with no behaviour here are plain storage.

Top module: `adc_seq_top`

## Requirements
- R1: Byte offsets are control 0x00, control-2 0x04, control-3 0x08, positive trim 0x0C, negative trim 0x10, flag clear 0x14 and result 0x18. After reset they read 0, 0, 0x0040, 0x200, 0x200, 0 and 0. The flag clear register always reads 0.
- R2: Writing control bit 0 as 1 drives `afe_ldo_on` high from the next cycle. `afe_adc_on` rises exactly N*32+1 cycles after that write edge, where N is control-3 bits 7:0. N=0 is treated as N=1.
- R3: Writing control bit 1 as 1 while enabled starts a conversion. Bit 1 reads 1 until the conversion completes and then reads 0. Control bit 4 (read-only flag) is set by the completion.
- R4: `afe_sample` is high for 1 cycle when control-2 bits 11:8 are 0, and for M*32 consecutive cycles for a nonzero value M.
- R5: `afe_soc` is a single-cycle pulse in the cycle right after the sample window ends.
- R6: When control-2 bits 15:12 are 0, the sample present on the cycle `afe_done` is high is stored after one synchronising register. A nonzero value S stores `afe_data` as seen S+1 cycles after the start pulse cycle, and `afe_done` is ignored.
- R7: With control bit 2 set, each completion starts a new sample window. Control-3 bits 15:8 = K adds K interval ticks between the completion and the next window; K=0 adds no delay. After bit 2 is cleared, the next completion clears the start bit.
- R8: `irq` is high exactly when the flag is set and control bit 5 (mask enable) is 1.
- R9: A write of any value to offset 0x14 clears the flag. A completion in the same cycle wins.
- R10: Writing start as 1 while a conversion is busy has no effect: no extra start pulse occurs.
- R11: Writing control bit 0 as 0 aborts: on the next cycle every analog output is low and the start bit reads 0. Re-enabling repeats the power-up delay.
- R12: The result register holds the 10-bit sample in bits 15:6 with bits 5:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the converter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| afe_ldo_on | output | 1 | Regulator enable |
| afe_adc_on | output | 1 | Converter enable |
| afe_sample | output | 1 | Sample switch closed |
| afe_soc | output | 1 | Start-of-conversion pulse |
| afe_data | input | 10 | Converter sample |
| afe_done | input | 1 | Converter done pulse |
| irq | output | 1 | Masked interrupt |

## Verification
Several properties are checked on every cycle. The start pulse is a one-cycle pulse that always follows the last sample-window cycle. The flag only rises after a completion. A clear write without a coinciding completion drops the flag. Disabling forces the sequencer to its off state and clears start. The exact power-up, window, store-delay and interval lengths, the captured values, the masking and the ignored busy start are shown only by the bench's scenarios, which compare against a clock-by-clock reference model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CNT_W     = 16;
    localparam int DLY_SHIFT = 5;   // delays count in units of 32 clocks

    localparam logic [2:0] W_CTRL  = 3'd0;
    localparam logic [2:0] W_CTRL2 = 3'd1;
    localparam logic [2:0] W_CTRL3 = 3'd2;
    localparam logic [2:0] W_TRIMP = 3'd3;
    localparam logic [2:0] W_TRIMN = 3'd4;
    localparam logic [2:0] W_CLR   = 3'd5;
    localparam logic [2:0] W_RES   = 3'd6;

    typedef enum logic [2:0] {
        ST_OFF, ST_PWR, ST_IDLE, ST_SMP, ST_SOC, ST_CNV, ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic       en;
        logic       cont;
        logic [7:0] pwr_dly;
        logic [7:0] gap;
        logic [3:0] smp;
        logic [3:0] sdel;
    } seq_cfg_t;

    function automatic logic [CNT_W-1:0] units_m1(input logic [7:0] n);
        return (CNT_W'(n) << DLY_SHIFT) - CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] win_load(input logic [3:0] m);
        return (m == 4'd0) ? '0 : units_m1({4'd0, m});
    endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
    parameter int TICK_DIV = 256000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i)      pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                    pre_q <= pre_q + PW'(1);
    end

    assign tick_o = run_i && (pre_q == LAST);
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int RES_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [4:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic              cmpl_i,
    input  logic [DATA_W-1:0] cap_i,
    output seq_cfg_t          cfg_o,
    output logic              start_o,
    output logic              irq_o
);
    localparam int PAD = RES_W - DATA_W;

    logic [15:0]      ctrl_q, ctrl2_q, ctrl3_q;
    logic [9:0]       trimp_q, trimn_q;
    logic [RES_W-1:0] res_q;
    logic             en_q, start_q, cont_q, mint_q, flag_q;
    logic [2:0]       widx;
    logic             wr_ctrl, wr_clr;

    assign widx    = addr_i[4:2];
    assign wr_ctrl = wr_i && (widx == W_CTRL);
    assign wr_clr  = wr_i && (widx == W_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ctrl2_q <= '0;
            ctrl3_q <= 16'h0040;
            trimp_q <= 10'h200;
            trimn_q <= 10'h200;
            en_q    <= 1'b0;
            cont_q  <= 1'b0;
            mint_q  <= 1'b0;
        end else if (wr_i) begin
            case (widx)
                W_CTRL: begin
                    ctrl_q <= wdata_i[15:0];
                    en_q   <= wdata_i[0];
                    cont_q <= wdata_i[2];
                    mint_q <= wdata_i[5];
                end
                W_CTRL2: ctrl2_q <= wdata_i[15:0];
                W_CTRL3: ctrl3_q <= wdata_i[15:0];
                W_TRIMP: trimp_q <= wdata_i[9:0];
                W_TRIMN: trimn_q <= wdata_i[9:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                       start_q <= 1'b0;
        else if (wr_ctrl && !wdata_i[0]) start_q <= 1'b0;
        else if (wr_ctrl && wdata_i[1])  start_q <= 1'b1;
        else if (cmpl_i && !cont_q)      start_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (cmpl_i) flag_q <= 1'b1;
        else if (wr_clr) flag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)         res_q <= '0;
        else if (cmpl_i) res_q <= {cap_i, {PAD{1'b0}}};
    end

    always_comb begin
        rdata_o = '0;
        case (widx)
            W_CTRL:  rdata_o[15:0] = (ctrl_q & 16'hFFC8)
                                   | {10'd0, mint_q, flag_q, 1'b0, cont_q, start_q, en_q};
            W_CTRL2: rdata_o[15:0] = ctrl2_q;
            W_CTRL3: rdata_o[15:0] = ctrl3_q;
            W_TRIMP: rdata_o[9:0]  = trimp_q;
            W_TRIMN: rdata_o[9:0]  = trimn_q;
            W_RES:   rdata_o[RES_W-1:0] = res_q;
            default: rdata_o = '0;
        endcase
    end

    assign cfg_o.en      = en_q;
    assign cfg_o.cont    = cont_q;
    assign cfg_o.pwr_dly = ctrl3_q[7:0];
    assign cfg_o.gap     = ctrl3_q[15:8];
    assign cfg_o.smp     = ctrl2_q[11:8];
    assign cfg_o.sdel    = ctrl2_q[15:12];
    assign start_o       = start_q;
    assign irq_o         = flag_q && mint_q;

    assert_flag_src_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(cmpl_i));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !cmpl_i) |=> !flag_q);

    assert_abort_start_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wdata_i[0]) |=> (!start_q && !en_q));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_cfg_t          cfg_i,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              adc_on_o,
    output logic              sample_o,
    output logic              soc_o,
    output logic              gap_o,
    output logic              cmpl_o,
    output logic [DATA_W-1:0] cap_o
);
    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              done_q;
    logic [DATA_W-1:0] data_q;
    logic              fire;
    logic              cnt_zero;

    assign cnt_zero = (cnt == '0);
    assign fire = cfg_i.en && (state == ST_CNV)
               && ((cfg_i.sdel == 4'd0) ? done_q : cnt_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_OFF;
            cnt    <= '0;
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            done_q <= done_i;
            data_q <= data_i;
            if (!cfg_i.en) begin
                state <= ST_OFF;
            end else begin
                case (state)
                    ST_OFF: begin
                        state <= ST_PWR;
                        cnt   <= units_m1((cfg_i.pwr_dly == 8'd0) ? 8'd1 : cfg_i.pwr_dly);
                    end
                    ST_PWR: begin
                        if (cnt_zero) state <= ST_IDLE;
                        else          cnt   <= cnt - CNT_W'(1);
                    end
                    ST_IDLE: begin
                        if (start_i) begin
                            state <= ST_SMP;
                            cnt   <= win_load(cfg_i.smp);
                        end
                    end
                    ST_SMP: begin
                        if (cnt_zero) state <= ST_SOC;
                        else          cnt   <= cnt - CNT_W'(1);
                    end
                    ST_SOC: begin
                        state <= ST_CNV;
                        cnt   <= CNT_W'(cfg_i.sdel);
                    end
                    ST_CNV: begin
                        if (fire) begin
                            if (!cfg_i.cont) begin
                                state <= ST_IDLE;
                            end else if (cfg_i.gap == 8'd0) begin
                                state <= ST_SMP;
                                cnt   <= win_load(cfg_i.smp);
                            end else begin
                                state <= ST_GAP;
                                cnt   <= CNT_W'(cfg_i.gap) - CNT_W'(1);
                            end
                        end else if (!cnt_zero) begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    ST_GAP: begin
                        if (tick_i) begin
                            if (cnt_zero) begin
                                state <= ST_SMP;
                                cnt   <= win_load(cfg_i.smp);
                            end else begin
                                cnt <= cnt - CNT_W'(1);
                            end
                        end
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    assign adc_on_o = cfg_i.en && (state != ST_OFF) && (state != ST_PWR);
    assign sample_o = cfg_i.en && (state == ST_SMP);
    assign soc_o    = cfg_i.en && (state == ST_SOC);
    assign gap_o    = (state == ST_GAP);
    assign cmpl_o   = fire;
    assign cap_o    = (cfg_i.sdel == 4'd0) ? data_q : data_i;

    assert_soc_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        soc_o |=> !soc_o);

    assert_soc_follows_window_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SMP && cnt_zero && cfg_i.en) |=> (state == ST_SOC));

    assert_disable_off_R11: assert property (@(posedge clk) disable iff (rst)
        !cfg_i.en |=> (state == ST_OFF));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int TICK_DIV = 256000,
    parameter int DATA_W   = 10,
    parameter int RES_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              afe_ldo_on,
    output logic              afe_adc_on,
    output logic              afe_sample,
    output logic              afe_soc,
    input  logic [DATA_W-1:0] afe_data,
    input  logic              afe_done,
    output logic              irq
);
    seq_cfg_t          cfg;
    logic              start, tick, gap, cmpl;
    logic [DATA_W-1:0] cap;

    adc_seq_regs #(.DATA_W(DATA_W), .RES_W(RES_W)) u_regs (
        .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .cmpl_i(cmpl),
        .cap_i(cap), .cfg_o(cfg), .start_o(start), .irq_o(irq)
    );

    adc_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst), .cfg_i(cfg), .start_i(start), .tick_i(tick),
        .done_i(afe_done), .data_i(afe_data), .adc_on_o(afe_adc_on),
        .sample_o(afe_sample), .soc_o(afe_soc), .gap_o(gap),
        .cmpl_o(cmpl), .cap_o(cap)
    );

    adc_seq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .run_i(gap), .tick_o(tick)
    );

    assign afe_ldo_on = cfg.en;

    assert_start_needs_ldo_R3: assert property (@(posedge clk) disable iff (rst)
        afe_soc |-> (afe_ldo_on && afe_adc_on && start));
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
    localparam int DIV = 20;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        afe_ldo_on, afe_adc_on, afe_sample, afe_soc, irq;
    logic [9:0]  afe_data = '0;
    logic        afe_done = 1'b0;

    always #2 clk = ~clk;

    adc_seq_top #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .afe_ldo_on(afe_ldo_on),
        .afe_adc_on(afe_adc_on), .afe_sample(afe_sample), .afe_soc(afe_soc),
        .afe_data(afe_data), .afe_done(afe_done), .irq(irq)
    );

    int checks = 0, fails = 0;
    bit done_flag = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_en, m_start, m_cont, m_mint, m_flag, m_ctrl, m_c2, m_c3, m_tp, m_tn, m_res;
    int m_st, m_cnt, m_pre, m_dq, m_vq;

    function automatic int m_win(int c2);
        int m = (c2 >> 8) & 15;
        return (m == 0) ? 0 : m * 32 - 1;
    endfunction

    function automatic int m_read(int a);
        case ((a >> 2) & 7)
            0: return (m_ctrl & 'hFFC8) | m_en | (m_start << 1) | (m_cont << 2)
                      | (m_flag << 4) | (m_mint << 5);
            1: return m_c2;
            2: return m_c3;
            3: return m_tp;
            4: return m_tn;
            6: return m_res;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en <= 0; m_start <= 0; m_cont <= 0; m_mint <= 0; m_flag <= 0;
            m_ctrl <= 0; m_c2 <= 0; m_c3 <= 'h40; m_tp <= 'h200; m_tn <= 'h200;
            m_res <= 0; m_st <= 0; m_cnt <= 0; m_pre <= 0; m_dq <= 0; m_vq <= 0;
        end else begin
            int sd, fire, capv, tick, wa, wd, pd;
            sd   = (m_c2 >> 12) & 15;
            fire = (m_en && m_st == 5 && ((sd == 0) ? m_dq : (m_cnt == 0))) ? 1 : 0;
            capv = (sd == 0) ? m_vq : int'(afe_data);
            tick = (m_st == 6 && m_pre == DIV - 1) ? 1 : 0;
            wa   = bus_wr ? int'(bus_addr[4:2]) : -1;
            wd   = int'(bus_wdata[15:0]);
            m_dq <= int'(afe_done);
            m_vq <= int'(afe_data);
            m_pre <= (m_st != 6 || m_pre == DIV - 1) ? 0 : m_pre + 1;
            if (fire) m_res <= capv << 6;
            if (fire) m_flag <= 1; else if (wa == 5) m_flag <= 0;
            if (wa == 0) begin
                m_ctrl <= wd; m_en <= wd & 1; m_cont <= (wd >> 2) & 1; m_mint <= (wd >> 5) & 1;
            end
            if (wa == 1) m_c2 <= wd;
            if (wa == 2) m_c3 <= wd;
            if (wa == 3) m_tp <= wd & 'h3FF;
            if (wa == 4) m_tn <= wd & 'h3FF;
            if (wa == 0 && !(wd & 1)) m_start <= 0;
            else if (wa == 0 && (wd & 2)) m_start <= 1;
            else if (fire && !m_cont) m_start <= 0;
            if (!m_en) m_st <= 0;
            else begin
                case (m_st)
                    0: begin pd = m_c3 & 255; if (pd == 0) pd = 1; m_st <= 1; m_cnt <= pd * 32 - 1; end
                    1: if (m_cnt == 0) m_st <= 2; else m_cnt <= m_cnt - 1;
                    2: if (m_start) begin m_st <= 3; m_cnt <= m_win(m_c2); end
                    3: if (m_cnt == 0) m_st <= 4; else m_cnt <= m_cnt - 1;
                    4: begin m_st <= 5; m_cnt <= sd; end
                    5: if (fire) begin
                           if (!m_cont) m_st <= 2;
                           else if (((m_c3 >> 8) & 255) == 0) begin m_st <= 3; m_cnt <= m_win(m_c2); end
                           else begin m_st <= 6; m_cnt <= ((m_c3 >> 8) & 255) - 1; end
                       end else if (m_cnt != 0) m_cnt <= m_cnt - 1;
                    6: if (tick) begin
                           if (m_cnt == 0) begin m_st <= 3; m_cnt <= m_win(m_c2); end
                           else m_cnt <= m_cnt - 1;
                       end
                    default: m_st <= 0;
                endcase
            end
        end
    end

    // ---------------- converter stub ----------------
    int cyc = 0, dcnt = 0, soc_n = 0, soc_val = 0, done_val = 0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        afe_data <= cyc[9:0];
        if (afe_done) afe_done <= 1'b0;
        if (afe_soc) begin
            soc_n++; soc_val = cyc & 1023; dcnt = LAT;
        end else if (dcnt > 0) begin
            dcnt--;
            if (dcnt == 0) begin afe_done <= 1'b1; done_val = cyc & 1023; end
        end
    end

    // ---------------- per-cycle comparison ----------------
    int run = 0, last_run = 0, soc_t = 0, soc_prev = 0;
    always @(negedge clk) begin
        #1;
        if (!rst && !done_flag) begin
            check("R2 ldo_on", int'(afe_ldo_on), m_en);
            check("R2 adc_on", int'(afe_adc_on), (m_en && m_st >= 2) ? 1 : 0);
            check("R4 sample", int'(afe_sample), (m_en && m_st == 3) ? 1 : 0);
            check("R5 soc", int'(afe_soc), (m_en && m_st == 4) ? 1 : 0);
            check("R8 irq", int'(irq), m_flag & m_mint);
            check("R1 rdata", int'(bus_rdata), m_read(int'(bus_addr)));
        end
        if (afe_sample) run++;
        else if (run > 0) begin last_run = run; run = 0; end
        if (afe_soc) begin soc_prev = soc_t; soc_t = cyc; end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk);
        bus_addr = 5'(a);
        #2;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n0, ctl, v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rd('h00, 0, "R1 ctrl reset");
        rd('h04, 0, "R1 ctrl2 reset");
        rd('h08, 'h40, "R1 ctrl3 reset");
        rd('h0C, 'h200, "R1 trimp reset");
        rd('h10, 'h200, "R1 trimn reset");
        rd('h14, 0, "R1 clear reads 0");
        rd('h18, 0, "R1 result reset");
        check("R11 outputs idle", int'({afe_ldo_on, afe_adc_on, afe_sample, afe_soc}), 0);

        // R2 power-up delay with N=1
        wr('h08, 'h0001);
        wr('h00, 'h21);
        repeat (32) @(negedge clk);
        #1 check("R2 adc_on still low", int'(afe_adc_on), 0);
        @(negedge clk);
        #1 check("R2 adc_on rises", int'(afe_adc_on), 1);

        // R3/R4/R6/R12 single conversion, handshake capture
        wr('h00, 'h23);
        rd('h00, 'h23, "R3 start reads busy");
        repeat (20) @(negedge clk);
        check("R4 one-cycle window", last_run, 1);
        rd('h18, done_val << 6, "R6 R12 handshake result");
        rd('h00, 'h31, "R3 start cleared, flag set");
        check("R8 irq with mask", int'(irq), 1);

        // R9 clear
        wr('h14, 'hDEAD);
        rd('h00, 'h21, "R9 flag cleared");
        check("R9 irq low", int'(irq), 0);

        // R10 start while busy
        n0 = soc_n;
        wr('h00, 'h23);
        @(negedge clk);
        wr('h00, 'h23);
        repeat (30) @(negedge clk);
        check("R10 single soc", soc_n - n0, 1);
        wr('h14, 0);

        // R8 masked
        wr('h00, 'h03);
        repeat (20) @(negedge clk);
        check("R8 irq masked", int'(irq), 0);
        rd('h00, 'h11, "R8 flag set while masked");
        wr('h14, 0);

        // R4 window of 32
        wr('h04, 'h0100);
        wr('h00, 'h23);
        repeat (60) @(negedge clk);
        check("R4 32-cycle window", last_run, 32);

        // R6 store delay 3
        wr('h04, 'h3000);
        wr('h00, 'h23);
        repeat (20) @(negedge clk);
        v = (soc_val + 4) & 1023;
        rd('h18, v << 6, "R6 R12 delayed store");

        // R7 continuous mode
        wr('h04, 'h2000);
        wr('h00, 'h27);
        repeat (30) @(negedge clk);
        check("R7 no interval spacing", soc_t - soc_prev, 5);
        wr('h08, 'h0201);
        repeat (120) @(negedge clk);
        check("R7 interval spacing", soc_t - soc_prev, 45);
        wr('h00, 'h21);
        repeat (100) @(negedge clk);
        rd('h00, 'h31, "R7 start cleared after cont off");
        wr('h14, 0);

        // R11 abort and re-power with N=0 treated as 1
        wr('h04, 'h0F00);
        wr('h00, 'h23);
        repeat (50) @(negedge clk);
        check("R11 sampling before abort", int'(afe_sample), 1);
        wr('h00, 'h20);
        #1 check("R11 outputs low", int'({afe_ldo_on, afe_adc_on, afe_sample, afe_soc}), 0);
        rd('h00, 'h20, "R11 start cleared");
        wr('h08, 'h0000);
        wr('h00, 'h21);
        repeat (32) @(negedge clk);
        #1 check("R2 N=0 adc_on low", int'(afe_adc_on), 0);
        @(negedge clk);
        #1 check("R2 N=0 adc_on rises", int'(afe_adc_on), 1);
        ctl = 0;
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule